// File: doc/BRIEF.md
# Serial Peripheral Interrupt Register Block

This block collects the event and condition lines of a serial peripheral's datapath into one seven-bit interrupt status word, holds a seven-bit enable mask, and drives a single registered interrupt line toward the processor. Software reaches it through a plain register port. A write is one cycle with `reg_wen` high. A read is combinational from `reg_addr`.

Pulse-type sources (bits 0, 1, 2, 5 and 6) latch into sticky status bits that software clears by writing ones to the status register. Condition-type sources (bits 3 and 4) are not latched. Their status bit follows the source line, so it clears only when the condition goes away. The mask cannot be written as a whole. One write-only register turns mask bits on, another turns them off, and a separate read-only register reports the current mask.

Top module: `irqc_top`

## Requirements
- R1: After reset, the status register reads 0, the mask register reads 0 and `irq_o` is low.
- R2: Registers are decoded at fixed byte offsets: status 0x04 (read, write-one-to-clear), enable 0x08 (write), disable 0x0C (write), mask 0x10 (read). A read of any other offset returns 0.
- R3: All four registers use bits 6:0 with one layout: bit 1 mode fault, bit 2 transmit above watermark, bit 3 transmit full, bit 4 receive not empty; bits 0, 5 and 6 are general sticky events. Bits 31:7 read as 0, and written bits 31:7 have no effect.
- R4: A sticky status bit becomes 1 on the clock edge at which its `src_in` line is high, and stays 1 after the line drops.
- R5: Writing the status register clears each sticky bit whose write-data bit is 1. Bits written with 0 are unchanged.
- R6: Condition bits 3 and 4 read as the value their `src_in` line had at the previous clock edge. Writing 1 to them in the status register has no effect.
- R7: If a sticky source is high in the same cycle that software writes 1 to that bit of the status register, the bit ends up set.
- R8: Writing the enable register sets each mask bit whose write-data bit is 1. Other mask bits are unchanged.
- R9: Writing the disable register clears each mask bit whose write-data bit is 1. Other mask bits are unchanged.
- R10: Reads of the enable and disable offsets return 0. Writes to the mask offset do not change the mask. Without an enable or disable write, the mask holds its value.
- R11: `irq_o` is registered. It is high one cycle after any bit is set in both the status register and the mask, as seen on the register port, and low one cycle after no bit is set in both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 7 | Event pulses and condition levels from the datapath |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a sticky source firing in the very cycle that a clear write targets the same bit. The bench produces it by raising `src_in` bit 2 and the status write in the same half-period, before one rising edge, and then reads the bit back. The one-cycle lag of `irq_o` is checked by sampling it on the first and on the second falling edge after an enable write, and again after a clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int IRQ_W = 7;

    // Condition-type bits: transmit full (3), receive not empty (4)
    localparam logic [IRQ_W-1:0] LEVEL_DEFAULT = 7'b001_1000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STAT,
        SEL_SET,
        SEL_CLR,
        SEL_MASK
    } reg_sel_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] OFS_STAT = 8'h04,
    parameter logic [ADDR_W-1:0] OFS_SET  = 8'h08,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_MASK = 8'h10
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        if      (addr == OFS_STAT) sel = SEL_STAT;
        else if (addr == OFS_SET)  sel = SEL_SET;
        else if (addr == OFS_CLR)  sel = SEL_CLR;
        else if (addr == OFS_MASK) sel = SEL_MASK;
        else                       sel = SEL_NONE;
    end
endmodule

// File: rtl/irqc_status.sv
module irqc_status #(
    parameter int           W          = irqc_pkg::IRQ_W,
    parameter logic [W-1:0] LEVEL_BITS = W'(irqc_pkg::LEVEL_DEFAULT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_in,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] status_o
);
    typedef struct packed {
        logic [W-1:0] stat;
    } stat_t;

    stat_t        st_d, st_q;
    logic [W-1:0] clr_eff;
    logic [W-1:0] nxt;

    assign clr_eff = clr_we ? clr_bits : '0;

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        if (LEVEL_BITS[gi]) begin : g_lvl
            assign nxt[gi] = src_in[gi];
        end else begin : g_stk
            assign nxt[gi] = src_in[gi] | (st_q.stat[gi] & ~clr_eff[gi]);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.stat;

    assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(status_o) & ~LEVEL_BITS & ~$past(clr_eff)) & ~status_o) == '0));

    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_we) |->
        ((status_o & ~LEVEL_BITS & $past(clr_bits) & ~$past(src_in)) == '0));

    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & LEVEL_BITS) == ($past(src_in) & LEVEL_BITS)));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_o & $past(src_in)) == $past(src_in)));
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask #(
    parameter int W = irqc_pkg::IRQ_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask_o
);
    typedef struct packed {
        logic [W-1:0] mask;
    } mask_t;

    mask_t mk_d, mk_q;

    always_comb begin
        mk_d = mk_q;
        if (set_we) mk_d.mask = mk_d.mask | bits;
        if (clr_we) mk_d.mask = mk_d.mask & ~bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mk_q <= '0;
        else        mk_q <= mk_d;
    end

    assign mask_o = mk_q.mask;

    assert_enable_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(set_we) && !$past(clr_we)) |-> ((mask_o & $past(bits)) == $past(bits)));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_we) |-> ((mask_o & $past(bits)) == '0));

    assert_mask_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(set_we) && !$past(clr_we)) |-> $stable(mask_o));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter int                W          = IRQ_W,
    parameter logic [W-1:0]      LEVEL_BITS = W'(LEVEL_DEFAULT),
    parameter logic [ADDR_W-1:0] OFS_STAT   = 8'h04,
    parameter logic [ADDR_W-1:0] OFS_SET    = 8'h08,
    parameter logic [ADDR_W-1:0] OFS_CLR    = 8'h0C,
    parameter logic [ADDR_W-1:0] OFS_MASK   = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      src_in,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    typedef struct packed {
        logic irq;
    } out_t;

    reg_sel_e     sel;
    logic [W-1:0] wbits;
    logic [W-1:0] status;
    logic [W-1:0] mask;
    out_t         o_d, o_q;

    assign wbits = reg_wdata[W-1:0];

    irqc_decode #(
        .ADDR_W  (ADDR_W),
        .OFS_STAT(OFS_STAT),
        .OFS_SET (OFS_SET),
        .OFS_CLR (OFS_CLR),
        .OFS_MASK(OFS_MASK)
    ) u_decode (
        .addr(reg_addr),
        .sel (sel)
    );

    irqc_status #(
        .W         (W),
        .LEVEL_BITS(LEVEL_BITS)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_in),
        .clr_we  (reg_wen && (sel == SEL_STAT)),
        .clr_bits(wbits),
        .status_o(status)
    );

    irqc_mask #(
        .W(W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .set_we(reg_wen && (sel == SEL_SET)),
        .clr_we(reg_wen && (sel == SEL_CLR)),
        .bits  (wbits),
        .mask_o(mask)
    );

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_STAT: reg_rdata[W-1:0] = status;
            SEL_MASK: reg_rdata[W-1:0] = mask;
            default:  reg_rdata = '0;
        endcase
    end

    always_comb begin
        o_d     = o_q;
        o_d.irq = |(status & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_o = o_q.irq;

    always_comb begin
        if (rst_n && (sel == SEL_SET || sel == SEL_CLR)) begin
            assert_wo_read_zero_R10: assert (reg_rdata == '0);
        end
        if (rst_n) begin
            assert_upper_zero_R3: assert (reg_rdata[DATA_W-1:W] == '0);
        end
    end

    assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask) == '0) |-> !irq_o);

    assert_irq_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(status) & $past(mask)) != '0);
endmodule

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  src_in = '0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_SET  = 8'h08;
    localparam logic [7:0] A_CLR  = 8'h0C;
    localparam logic [7:0] A_MASK = 8'h10;

    always #5 clk = ~clk;

    irqc_top u_irqc_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .reg_wen  (reg_wen),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_o    (irq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [6:0] v);
        @(negedge clk);
        src_in = v;
        @(negedge clk);
        src_in = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(A_STAT, d); check("R1 status", d, 0);
        rd(A_MASK, d); check("R1 mask", d, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        pulse(7'h02);
        rd(A_STAT, d); check("R4 R3 mode-fault bit1 sticky", d, 32'h02);
        pulse(7'h60);
        rd(A_STAT, d); check("R4 bits 5,6 sticky", d, 32'h62);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        wr(A_STAT, 32'h20);
        rd(A_STAT, d); check("R5 clear bit5 only", d, 32'h42);
        wr(A_STAT, 32'h00);
        rd(A_STAT, d); check("R5 zero write no effect", d, 32'h42);
        wr(A_STAT, 32'h42);
        rd(A_STAT, d); check("R5 clear remaining", d, 32'h00);
    endtask

    task automatic t_level();
        logic [31:0] d;
        @(negedge clk); src_in = 7'h18;
        @(negedge clk);
        rd(A_STAT, d); check("R6 R3 level bits 3,4 follow", d, 32'h18);
        wr(A_STAT, 32'h18);
        rd(A_STAT, d); check("R6 w1c ignored on level bits", d, 32'h18);
        src_in = 7'h10;
        @(negedge clk);
        rd(A_STAT, d); check("R6 tx-full drops with source", d, 32'h10);
        src_in = '0;
        @(negedge clk);
        rd(A_STAT, d); check("R6 rx-not-empty drops", d, 32'h00);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        pulse(7'h04);
        @(negedge clk);
        src_in = 7'h04; reg_wen = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h04;
        @(negedge clk);
        src_in = '0; reg_wen = 1'b0; reg_wdata = '0;
        rd(A_STAT, d); check("R7 set beats clear", d, 32'h04);
        wr(A_STAT, 32'h04);
        rd(A_STAT, d); check("R7 later clear works", d, 32'h00);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(A_SET, 32'h06);
        rd(A_MASK, d); check("R8 enable 0x06", d, 32'h06);
        wr(A_SET, 32'h01);
        rd(A_MASK, d); check("R8 enable adds bit0", d, 32'h07);
        wr(A_CLR, 32'h04);
        rd(A_MASK, d); check("R9 disable bit2", d, 32'h03);
        wr(A_SET, 32'hFFFF_FF80);
        rd(A_MASK, d); check("R3 upper write bits ignored", d, 32'h03);
    endtask

    task automatic t_ro_wo();
        logic [31:0] d;
        rd(A_SET, d); check("R10 enable reads 0", d, 0);
        rd(A_CLR, d); check("R10 disable reads 0", d, 0);
        rd(8'h14, d); check("R2 unmapped reads 0", d, 0);
        wr(A_MASK, 32'h7F);
        rd(A_MASK, d); check("R10 mask offset write ignored", d, 32'h03);
        wr(8'h14, 32'h7F);
        rd(A_MASK, d); check("R2 unmapped write ignored", d, 32'h03);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(A_CLR, 32'h7F);
        wr(A_STAT, 32'h7F);
        pulse(7'h02);
        @(negedge clk);
        check("R11 masked event no irq", {31'b0, irq_o}, 0);
        wr(A_SET, 32'h02);
        check("R11 irq not yet (registered)", {31'b0, irq_o}, 0);
        @(negedge clk);
        check("R11 irq asserted", {31'b0, irq_o}, 1);
        wr(A_STAT, 32'h02);
        rd(A_STAT, d); check("R11 status cleared", d, 0);
        check("R11 irq still high one cycle", {31'b0, irq_o}, 1);
        @(negedge clk);
        check("R11 irq deasserted", {31'b0, irq_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sticky();
        t_w1c();
        t_level();
        t_set_wins();
        t_mask();
        t_ro_wo();
        t_irq();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule